// File: doc/BRIEF.md
# Compare-and-Branch Pair Fuser

This block sits between a two-wide instruction decoder and the uop queue. Each cycle it looks at two adjacent decoded instructions, slot 0 being the older. When slot 0 sets flags and slot 1 is a conditional branch, and the pair meets the eligibility rules, the block replaces them with one compare-and-branch uop. Otherwise both instructions pass through unchanged. The eligibility rules depend on the opcode class, the operand kinds and the branch condition. Outputs are registered, so a pair presented in cycle N appears on the outputs after the clock edge that ends cycle N.

A fused uop occupies one queue slot. For accounting it still stands for two instructions: it carries an instruction count of two and advances the running instruction total by two. Its fault address is the address of the flag-setting instruction. The condition subsets that allow add/sub and inc/dec to fuse come from two 16-bit parameter masks, each indexed by the 4-bit condition code.

Top module: `fuse_detect`

## Requirements
- R1: When slot 0 is a compare (class 1) or a test (class 2), slot 1 is a conditional branch (class 7), and both slots are valid, the next cycle shows `out_valid`=01 and `out_fused[0]`=1. Uop 0 carries slot 0's class, operand kinds and operand fields, slot 1's condition and target, and `out_wflags[0]`=1. Operand kind codes are: none 0, register 1, memory 2, immediate 3.
- R2: A compare or test with a memory operand in either position and an immediate operand in either position never fuses. A compare with one memory operand and one register operand does fuse.
- R3: Add (3) or sub (4) followed by a branch fuses only if bit `cond` of `ADDSUB_CC_MASK` is set. Inc (5) or dec (6) followed by a branch fuses only if bit `cond` of `INCDEC_CC_MASK` is set. The defaults are 16'hF0FC and 16'hF030.
- R4: No fusion takes place in any of these cases: slot 1 is not a branch, for example an intervening move (9); slot 0 is invalid; or a flag-setter sits in slot 1 and its branch arrives in slot 0 of the next cycle.
- R5: A decrement-and-loop instruction (class 8), which sets no flags, never takes part in a fused pair, whether it sits in slot 0 or in slot 1.
- R6: Without fusion, `out_valid` equals the previous cycle's `in_valid`, and each uop copies its slot's fields. Each such uop has `out_icnt`=1 and `out_fused`=0. `out_wflags` is 1 exactly for classes 1 to 6.
- R7: A fused uop has `out_icnt[0]`=2. `inst_total` advances each cycle by the number of valid input instructions, so a fused pair adds two.
- R8: The `out_pc[0]` of a fused uop equals slot 0's address, which is the address a fault on its memory operand reports.
- R9: `in_taken` equals `in_valid` in the same cycle, so upstream learns that both instructions were taken when they fuse.
- R10: While `rst_n` is low at a clock edge, `out_valid` becomes 00 and `inst_total` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 2 | Slot valid bits |
| in_pc | input | 2x PC_W | Instruction addresses |
| in_cls | input | 2x4 | Opcode class |
| in_kind_a | input | 2x2 | First operand kind |
| in_kind_b | input | 2x2 | Second operand kind |
| in_opnd_a | input | 2x OPND_W | First operand identifier |
| in_opnd_b | input | 2x OPND_W | Second operand identifier |
| in_cond | input | 2x4 | Branch condition code |
| in_target | input | 2x PC_W | Branch target |
| in_taken | output | 2 | Instructions consumed this cycle |
| out_valid | output | 2 | Uop valid mask |
| out_fused | output | 2 | Uop is a fused pair |
| out_cls | output | 2x4 | Uop class (flag-setter class if fused) |
| out_kind_a | output | 2x2 | First operand kind |
| out_kind_b | output | 2x2 | Second operand kind |
| out_opnd_a | output | 2x OPND_W | First operand identifier |
| out_opnd_b | output | 2x OPND_W | Second operand identifier |
| out_cond | output | 2x4 | Condition code |
| out_target | output | 2x PC_W | Branch target |
| out_pc | output | 2x PC_W | Fault / instruction address |
| out_icnt | output | 2x2 | Architectural instructions in the uop |
| out_wflags | output | 2 | Uop writes flags |
| inst_total | output | CNT_W | Running instruction count |

## Verification
The bench keeps `ADDSUB_CC_MASK` at its default of 16'hF0FC and narrows `INCDEC_CC_MASK` to 16'h0030, which allows only equal and not-equal. With that narrower mask, inc with condition 14 and dec with condition 2 must be refused even though the default mask would accept the first. This shows that the table is actually consulted and not hard-wired. Operand kinds are swept through memory, immediate and register combinations, which covers both the blocked memory-with-immediate case and the allowed memory-with-register case.

// File: rtl/fuse_pkg.sv
`timescale 1ns/1ps
// fuse_pkg: class and operand-kind encodings shared by the pair fuser.
// Assumes a 4-bit class field and a 2-bit operand-kind field at the ports.
package fuse_pkg;

    localparam int NSLOT = 2;

    typedef enum logic [3:0] {
        CLS_OTHER   = 4'd0,
        CLS_CMP     = 4'd1,
        CLS_TEST    = 4'd2,
        CLS_ADD     = 4'd3,
        CLS_SUB     = 4'd4,
        CLS_INC     = 4'd5,
        CLS_DEC     = 4'd6,
        CLS_JCC     = 4'd7,
        CLS_LOOPDEC = 4'd8,
        CLS_MOV     = 4'd9
    } op_cls_e;

    typedef enum logic [1:0] {
        KND_NONE = 2'd0,
        KND_REG  = 2'd1,
        KND_MEM  = 2'd2,
        KND_IMM  = 2'd3
    } opnd_kind_e;

    // Classes that write the flags register.
    function automatic logic sets_flags(input logic [3:0] c);
        return (c >= CLS_CMP) && (c <= CLS_DEC);
    endfunction

endpackage

// File: rtl/fuse_pair_check.sv
`timescale 1ns/1ps
// fuse_pair_check: decides whether the lead (older) and follow instructions
// form a fusible compare-and-branch pair. Purely combinational.
// Assumes lead is directly followed by follow in program order.
module fuse_pair_check
    import fuse_pkg::*;
#(
    parameter logic [15:0] ADDSUB_CC_MASK = 16'hF0FC,
    parameter logic [15:0] INCDEC_CC_MASK = 16'hF030
) (
    input  logic       lead_vld,
    input  logic       follow_vld,
    input  logic [3:0] lead_cls,
    input  logic [3:0] follow_cls,
    input  logic [1:0] lead_ka,
    input  logic [1:0] lead_kb,
    input  logic [3:0] follow_cond,
    output logic       pair_ok
);

    logic has_mem;
    logic has_imm;
    logic lead_ok;

    // Classify the lead instruction's operand mix.
    always_comb begin
        has_mem = (lead_ka == KND_MEM) || (lead_kb == KND_MEM);
        has_imm = (lead_ka == KND_IMM) || (lead_kb == KND_IMM);
    end

    // Per-class eligibility, including the condition-code tables.
    always_comb begin
        case (lead_cls)
            CLS_CMP, CLS_TEST: lead_ok = !(has_mem && has_imm);
            CLS_ADD, CLS_SUB:  lead_ok = ADDSUB_CC_MASK[follow_cond];
            CLS_INC, CLS_DEC:  lead_ok = INCDEC_CC_MASK[follow_cond];
            default:           lead_ok = 1'b0;
        endcase
    end

    // Final pair decision: both valid and the follower is a conditional branch.
    always_comb begin
        pair_ok = lead_vld && follow_vld && (follow_cls == CLS_JCC) && lead_ok;
    end

endmodule

// File: rtl/fuse_uop_build.sv
`timescale 1ns/1ps
// fuse_uop_build: forms the next-cycle uop fields for both output slots.
// With pair_ok, slot 0 becomes the fused uop and slot 1 is dropped;
// otherwise each slot mirrors its input instruction.
module fuse_uop_build
    import fuse_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int OPND_W = 4
) (
    input  logic                         pair_ok,
    input  logic [NSLOT-1:0]             in_valid,
    input  logic [NSLOT-1:0][PC_W-1:0]   in_pc,
    input  logic [NSLOT-1:0][3:0]        in_cls,
    input  logic [NSLOT-1:0][1:0]        in_kind_a,
    input  logic [NSLOT-1:0][1:0]        in_kind_b,
    input  logic [NSLOT-1:0][OPND_W-1:0] in_opnd_a,
    input  logic [NSLOT-1:0][OPND_W-1:0] in_opnd_b,
    input  logic [NSLOT-1:0][3:0]        in_cond,
    input  logic [NSLOT-1:0][PC_W-1:0]   in_target,
    output logic [NSLOT-1:0]             nx_valid,
    output logic [NSLOT-1:0]             nx_fused,
    output logic [NSLOT-1:0][PC_W-1:0]   nx_pc,
    output logic [NSLOT-1:0][3:0]        nx_cls,
    output logic [NSLOT-1:0][1:0]        nx_kind_a,
    output logic [NSLOT-1:0][1:0]        nx_kind_b,
    output logic [NSLOT-1:0][OPND_W-1:0] nx_opnd_a,
    output logic [NSLOT-1:0][OPND_W-1:0] nx_opnd_b,
    output logic [NSLOT-1:0][3:0]        nx_cond,
    output logic [NSLOT-1:0][PC_W-1:0]   nx_target,
    output logic [NSLOT-1:0][1:0]        nx_icnt,
    output logic [NSLOT-1:0]             nx_wflags
);

    // Operand, class and address fields pass straight through in both cases.
    assign nx_pc     = in_pc;
    assign nx_cls    = in_cls;
    assign nx_kind_a = in_kind_a;
    assign nx_kind_b = in_kind_b;
    assign nx_opnd_a = in_opnd_a;
    assign nx_opnd_b = in_opnd_b;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic            vld_s;
        logic            fus_s;
        logic [3:0]      cond_s;
        logic [PC_W-1:0] tgt_s;
        logic [1:0]      icnt_s;
        logic            wfl_s;

        // Select pass-through or fused content for this slot.
        always_comb begin
            vld_s  = in_valid[s];
            fus_s  = 1'b0;
            cond_s = in_cond[s];
            tgt_s  = in_target[s];
            icnt_s = 2'd1;
            wfl_s  = sets_flags(in_cls[s]);
            if (pair_ok) begin
                if (s == 0) begin
                    fus_s  = 1'b1;
                    cond_s = in_cond[1];
                    tgt_s  = in_target[1];
                    icnt_s = 2'd2;
                    wfl_s  = 1'b1;
                end else begin
                    vld_s  = 1'b0;
                end
            end
        end

        assign nx_valid[s]  = vld_s;
        assign nx_fused[s]  = fus_s;
        assign nx_cond[s]   = cond_s;
        assign nx_target[s] = tgt_s;
        assign nx_icnt[s]   = icnt_s;
        assign nx_wflags[s] = wfl_s;
    end

endmodule

// File: rtl/fuse_inst_count.sv
`timescale 1ns/1ps
// fuse_inst_count: running count of architectural instructions emitted,
// summing each valid uop's instruction count. Wraps at 2**CNT_W.
module fuse_inst_count
    import fuse_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSLOT-1:0]      uop_valid,
    input  logic [NSLOT-1:0][1:0] uop_icnt,
    output logic [CNT_W-1:0]      inst_total
);

    logic [CNT_W-1:0] step;

    // Sum the instruction counts of this cycle's valid uops.
    always_comb begin
        step = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (uop_valid[s]) step = step + CNT_W'(uop_icnt[s]);
        end
    end

    // Accumulate, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) inst_total <= '0;
        else        inst_total <= inst_total + step;
    end

endmodule

// File: rtl/fuse_detect.sv
`timescale 1ns/1ps
// fuse_detect: two-wide compare-and-branch fuser. Detects a fusible
// flag-setter/branch pair in slots 0/1 and registers the resulting uops.
// Assumes slot 0 is older and that all presented instructions are accepted.
module fuse_detect
    import fuse_pkg::*;
#(
    parameter int          PC_W           = 32,
    parameter int          OPND_W         = 4,
    parameter int          CNT_W          = 16,
    parameter logic [15:0] ADDSUB_CC_MASK = 16'hF0FC,
    parameter logic [15:0] INCDEC_CC_MASK = 16'hF030
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   in_valid,
    input  logic [1:0][PC_W-1:0]         in_pc,
    input  logic [1:0][3:0]              in_cls,
    input  logic [1:0][1:0]              in_kind_a,
    input  logic [1:0][1:0]              in_kind_b,
    input  logic [1:0][OPND_W-1:0]       in_opnd_a,
    input  logic [1:0][OPND_W-1:0]       in_opnd_b,
    input  logic [1:0][3:0]              in_cond,
    input  logic [1:0][PC_W-1:0]         in_target,
    output logic [1:0]                   in_taken,
    output logic [1:0]                   out_valid,
    output logic [1:0]                   out_fused,
    output logic [1:0][3:0]              out_cls,
    output logic [1:0][1:0]              out_kind_a,
    output logic [1:0][1:0]              out_kind_b,
    output logic [1:0][OPND_W-1:0]       out_opnd_a,
    output logic [1:0][OPND_W-1:0]       out_opnd_b,
    output logic [1:0][3:0]              out_cond,
    output logic [1:0][PC_W-1:0]         out_target,
    output logic [1:0][PC_W-1:0]         out_pc,
    output logic [1:0][1:0]              out_icnt,
    output logic [1:0]                   out_wflags,
    output logic [CNT_W-1:0]             inst_total
);

    logic                         pair_ok;
    logic [NSLOT-1:0]             nx_valid;
    logic [NSLOT-1:0]             nx_fused;
    logic [NSLOT-1:0][PC_W-1:0]   nx_pc;
    logic [NSLOT-1:0][3:0]        nx_cls;
    logic [NSLOT-1:0][1:0]        nx_kind_a;
    logic [NSLOT-1:0][1:0]        nx_kind_b;
    logic [NSLOT-1:0][OPND_W-1:0] nx_opnd_a;
    logic [NSLOT-1:0][OPND_W-1:0] nx_opnd_b;
    logic [NSLOT-1:0][3:0]        nx_cond;
    logic [NSLOT-1:0][PC_W-1:0]   nx_target;
    logic [NSLOT-1:0][1:0]        nx_icnt;
    logic [NSLOT-1:0]             nx_wflags;

    // Every presented instruction is consumed; a fused pair takes both.
    assign in_taken = in_valid;

    fuse_pair_check #(
        .ADDSUB_CC_MASK (ADDSUB_CC_MASK),
        .INCDEC_CC_MASK (INCDEC_CC_MASK)
    ) u_check (
        .lead_vld    (in_valid[0]),
        .follow_vld  (in_valid[1]),
        .lead_cls    (in_cls[0]),
        .follow_cls  (in_cls[1]),
        .lead_ka     (in_kind_a[0]),
        .lead_kb     (in_kind_b[0]),
        .follow_cond (in_cond[1]),
        .pair_ok     (pair_ok)
    );

    fuse_uop_build #(
        .PC_W   (PC_W),
        .OPND_W (OPND_W)
    ) u_build (
        .pair_ok   (pair_ok),
        .in_valid  (in_valid),
        .in_pc     (in_pc),
        .in_cls    (in_cls),
        .in_kind_a (in_kind_a),
        .in_kind_b (in_kind_b),
        .in_opnd_a (in_opnd_a),
        .in_opnd_b (in_opnd_b),
        .in_cond   (in_cond),
        .in_target (in_target),
        .nx_valid  (nx_valid),
        .nx_fused  (nx_fused),
        .nx_pc     (nx_pc),
        .nx_cls    (nx_cls),
        .nx_kind_a (nx_kind_a),
        .nx_kind_b (nx_kind_b),
        .nx_opnd_a (nx_opnd_a),
        .nx_opnd_b (nx_opnd_b),
        .nx_cond   (nx_cond),
        .nx_target (nx_target),
        .nx_icnt   (nx_icnt),
        .nx_wflags (nx_wflags)
    );

    fuse_inst_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .uop_valid  (nx_valid),
        .uop_icnt   (nx_icnt),
        .inst_total (inst_total)
    );

    // Output register stage toward the uop queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= '0;
            out_fused  <= '0;
            out_cls    <= '0;
            out_kind_a <= '0;
            out_kind_b <= '0;
            out_opnd_a <= '0;
            out_opnd_b <= '0;
            out_cond   <= '0;
            out_target <= '0;
            out_pc     <= '0;
            out_icnt   <= '0;
            out_wflags <= '0;
        end else begin
            out_valid  <= nx_valid;
            out_fused  <= nx_fused;
            out_cls    <= nx_cls;
            out_kind_a <= nx_kind_a;
            out_kind_b <= nx_kind_b;
            out_opnd_a <= nx_opnd_a;
            out_opnd_b <= nx_opnd_b;
            out_cond   <= nx_cond;
            out_target <= nx_target;
            out_pc     <= nx_pc;
            out_icnt   <= nx_icnt;
            out_wflags <= nx_wflags;
        end
    end

    AST_FUSED_ONE_UOP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[0] && out_fused[0]) |-> (!out_valid[1] && out_wflags[0])); // R1

    AST_MEMIMM_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (((in_cls[0] == CLS_CMP) || (in_cls[0] == CLS_TEST)) &&
         ((in_kind_a[0] == KND_MEM) || (in_kind_b[0] == KND_MEM)) &&
         ((in_kind_a[0] == KND_IMM) || (in_kind_b[0] == KND_IMM)))
        |=> !out_fused[0]); // R2

    AST_GAP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid[0] || (in_cls[1] != CLS_JCC)) |=> !out_fused[0]); // R4

    AST_LOOP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_cls[0] == CLS_LOOPDEC) || (in_cls[1] == CLS_LOOPDEC)) |=> !out_fused[0]); // R5

    AST_FUSED_ICNT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[0] && out_fused[0]) |-> (out_icnt[0] == 2'd2)); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (inst_total ==
            CNT_W'($past(inst_total) + CNT_W'($countones($past(in_valid)))))); // R7

    AST_FAULT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[0] && out_fused[0] && $past(rst_n)) |-> (out_pc[0] == $past(in_pc[0]))); // R8

endmodule

// File: tb/fuse_detect_test.sv
`timescale 1ns/1ps
module fuse_detect_test;

    localparam int          PC_W = 32;
    localparam int          OW   = 4;
    localparam int          CW   = 16;
    localparam logic [15:0] AS_MASK = 16'hF0FC;
    localparam logic [15:0] ID_MASK = 16'h0030;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]            in_valid = '0;
    logic [1:0][PC_W-1:0]  in_pc = '0;
    logic [1:0][3:0]       in_cls = '0;
    logic [1:0][1:0]       in_kind_a = '0;
    logic [1:0][1:0]       in_kind_b = '0;
    logic [1:0][OW-1:0]    in_opnd_a = '0;
    logic [1:0][OW-1:0]    in_opnd_b = '0;
    logic [1:0][3:0]       in_cond = '0;
    logic [1:0][PC_W-1:0]  in_target = '0;
    logic [1:0]            in_taken;
    logic [1:0]            out_valid;
    logic [1:0]            out_fused;
    logic [1:0][3:0]       out_cls;
    logic [1:0][1:0]       out_kind_a;
    logic [1:0][1:0]       out_kind_b;
    logic [1:0][OW-1:0]    out_opnd_a;
    logic [1:0][OW-1:0]    out_opnd_b;
    logic [1:0][3:0]       out_cond;
    logic [1:0][PC_W-1:0]  out_target;
    logic [1:0][PC_W-1:0]  out_pc;
    logic [1:0][1:0]       out_icnt;
    logic [1:0]            out_wflags;
    logic [CW-1:0]         inst_total;

    fuse_detect #(
        .PC_W(PC_W), .OPND_W(OW), .CNT_W(CW),
        .ADDSUB_CC_MASK(AS_MASK), .INCDEC_CC_MASK(ID_MASK)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_pc(in_pc), .in_cls(in_cls),
        .in_kind_a(in_kind_a), .in_kind_b(in_kind_b),
        .in_opnd_a(in_opnd_a), .in_opnd_b(in_opnd_b),
        .in_cond(in_cond), .in_target(in_target),
        .in_taken(in_taken),
        .out_valid(out_valid), .out_fused(out_fused), .out_cls(out_cls),
        .out_kind_a(out_kind_a), .out_kind_b(out_kind_b),
        .out_opnd_a(out_opnd_a), .out_opnd_b(out_opnd_b),
        .out_cond(out_cond), .out_target(out_target), .out_pc(out_pc),
        .out_icnt(out_icnt), .out_wflags(out_wflags), .inst_total(inst_total)
    );

    always #2 clk = ~clk;

    typedef struct {
        string           tag;
        logic [1:0]      valid;
        logic            fused;
        logic [3:0]      cls0;
        logic [1:0]      ka0;
        logic [OW-1:0]   oa0;
        logic [3:0]      cond0;
        logic [PC_W-1:0] tgt0;
        logic [PC_W-1:0] pc0;
        logic [1:0]      icnt0;
        logic            wfl0;
        logic [3:0]      cls1;
        logic [PC_W-1:0] pc1;
        logic            wfl1;
        logic [CW-1:0]   total;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;
    int seq = 0;
    logic [CW-1:0] tot = '0;

    logic [1:0]      st_v;
    logic [1:0][3:0] st_cls, st_cond;
    logic [1:0][1:0] st_ka, st_kb;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic put(input int s, input bit v, input logic [3:0] cls,
                       input logic [1:0] ka, input logic [1:0] kb, input logic [3:0] cond);
        st_v[s] = v; st_cls[s] = cls; st_ka[s] = ka; st_kb[s] = kb; st_cond[s] = cond;
    endtask

    function automatic bit fl(input logic [3:0] c);
        return (c >= 4'd1) && (c <= 4'd6);
    endfunction

    // Driver: applies staged slots at a falling edge and records the expectation.
    task automatic issue(input string tag);
        exp_t e;
        bit mem, imm, ok, fz;
        @(negedge clk);
        seq++;
        for (int s = 0; s < 2; s++) begin
            in_valid[s]  = st_v[s];
            in_cls[s]    = st_cls[s];
            in_kind_a[s] = st_ka[s];
            in_kind_b[s] = st_kb[s];
            in_cond[s]   = st_cond[s];
            in_pc[s]     = PC_W'(32'h1000 + seq * 16 + s * 4);
            in_target[s] = PC_W'(32'h8000 + seq * 32 + s);
            in_opnd_a[s] = OW'(seq + s);
            in_opnd_b[s] = OW'(seq + 7 + s);
        end
        mem = (st_ka[0] == 2'd2) || (st_kb[0] == 2'd2);
        imm = (st_ka[0] == 2'd3) || (st_kb[0] == 2'd3);
        case (st_cls[0])
            4'd1, 4'd2: ok = !(mem && imm);
            4'd3, 4'd4: ok = AS_MASK[st_cond[1]];
            4'd5, 4'd6: ok = ID_MASK[st_cond[1]];
            default:    ok = 1'b0;
        endcase
        fz = st_v[0] && st_v[1] && (st_cls[1] == 4'd7) && ok;
        tot = tot + CW'(st_v[0]) + CW'(st_v[1]);
        e.tag   = tag;
        e.valid = fz ? 2'b01 : st_v;
        e.fused = fz;
        e.cls0  = st_cls[0];
        e.ka0   = st_ka[0];
        e.oa0   = in_opnd_a[0];
        e.cond0 = fz ? st_cond[1] : st_cond[0];
        e.tgt0  = fz ? in_target[1] : in_target[0];
        e.pc0   = in_pc[0];
        e.icnt0 = fz ? 2'd2 : 2'd1;
        e.wfl0  = fz ? 1'b1 : fl(st_cls[0]);
        e.cls1  = st_cls[1];
        e.pc1   = in_pc[1];
        e.wfl1  = fl(st_cls[1]);
        e.total = tot;
        sb.push_back(e);
        #1;
        chk({tag, "/R9"}, "in_taken", 64'(in_taken), 64'(st_v));
    endtask

    // Monitor: after each rising edge, compare registered uops to the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "out_valid", 64'(out_valid), 64'(e.valid));
                chk(e.tag, "out_fused0", 64'(out_fused[0]), 64'(e.fused));
                chk({e.tag, "/R7"}, "inst_total", 64'(inst_total), 64'(e.total));
                if (e.valid[0]) begin
                    chk(e.tag, "cls0", 64'(out_cls[0]), 64'(e.cls0));
                    chk(e.tag, "kind_a0", 64'(out_kind_a[0]), 64'(e.ka0));
                    chk(e.tag, "opnd_a0", 64'(out_opnd_a[0]), 64'(e.oa0));
                    chk(e.tag, "cond0", 64'(out_cond[0]), 64'(e.cond0));
                    chk(e.tag, "target0", 64'(out_target[0]), 64'(e.tgt0));
                    chk({e.tag, "/R8"}, "pc0", 64'(out_pc[0]), 64'(e.pc0));
                    chk({e.tag, "/R7"}, "icnt0", 64'(out_icnt[0]), 64'(e.icnt0));
                    chk(e.tag, "wflags0", 64'(out_wflags[0]), 64'(e.wfl0));
                end
                if (e.valid[1]) begin
                    chk({e.tag, "/R6"}, "cls1", 64'(out_cls[1]), 64'(e.cls1));
                    chk({e.tag, "/R6"}, "pc1", 64'(out_pc[1]), 64'(e.pc1));
                    chk({e.tag, "/R6"}, "icnt1", 64'(out_icnt[1]), 64'd1);
                    chk({e.tag, "/R6"}, "wflags1", 64'(out_wflags[1]), 64'(e.wfl1));
                    chk({e.tag, "/R6"}, "fused1", 64'(out_fused[1]), 64'd0);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        st_v = '0; st_cls = '0; st_cond = '0; st_ka = '0; st_kb = '0;
        in_valid = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "out_valid", 64'(out_valid), 64'd0);
        chk("R10", "inst_total", 64'(inst_total), 64'd0);
        in_valid = '0;
        rst_n = 1'b1;

        // R1: compare reg/reg, test reg/imm with a following branch
        put(0, 1, 4'd1, 2'd1, 2'd1, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd4); issue("R1 cmp-reg");
        put(0, 1, 4'd2, 2'd1, 2'd3, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd5); issue("R1 test-imm");
        // R2: memory with immediate blocked, memory with register allowed
        put(0, 1, 4'd1, 2'd2, 2'd3, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd4); issue("R2 cmp-mem-imm");
        put(0, 1, 4'd2, 2'd3, 2'd2, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd4); issue("R2 test-imm-mem");
        put(0, 1, 4'd1, 2'd2, 2'd1, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd5); issue("R2 cmp-mem-reg");
        // R3: add/sub and inc/dec condition tables
        put(0, 1, 4'd3, 2'd1, 2'd1, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd4);  issue("R3 add-E");
        put(0, 1, 4'd3, 2'd1, 2'd3, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd0);  issue("R3 add-O");
        put(0, 1, 4'd3, 2'd1, 2'd1, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd8);  issue("R3 add-S");
        put(0, 1, 4'd4, 2'd1, 2'd1, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd2);  issue("R3 sub-B");
        put(0, 1, 4'd5, 2'd1, 2'd0, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd4);  issue("R3 inc-E");
        put(0, 1, 4'd5, 2'd1, 2'd0, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd14); issue("R3 inc-LE");
        put(0, 1, 4'd6, 2'd1, 2'd0, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd2);  issue("R3 dec-B");
        // R4: intervening move, invalid lead, split across cycles
        put(0, 1, 4'd1, 2'd1, 2'd1, 4'd0); put(1, 1, 4'd9, 2'd1, 2'd1, 4'd0);  issue("R4 cmp-mov");
        put(0, 0, 4'd1, 2'd1, 2'd1, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd4);  issue("R4 lead-invalid");
        put(0, 1, 4'd9, 2'd1, 2'd1, 4'd0); put(1, 1, 4'd1, 2'd1, 2'd1, 4'd0);  issue("R4 split-a");
        put(0, 1, 4'd7, 2'd0, 2'd0, 4'd4); put(1, 1, 4'd9, 2'd1, 2'd1, 4'd0);  issue("R4 split-b");
        // R5: decrement-and-loop in either slot
        put(0, 1, 4'd8, 2'd1, 2'd0, 4'd5); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd5);  issue("R5 loop-lead");
        put(0, 1, 4'd1, 2'd1, 2'd1, 4'd0); put(1, 1, 4'd8, 2'd1, 2'd0, 4'd5);  issue("R5 loop-follow");
        // R6: plain pass-through, single slot, idle
        put(0, 1, 4'd9, 2'd1, 2'd1, 4'd0); put(1, 1, 4'd0, 2'd1, 2'd2, 4'd0);  issue("R6 mov-other");
        put(0, 1, 4'd4, 2'd1, 2'd3, 4'd0); put(1, 0, 4'd7, 2'd0, 2'd0, 4'd4);  issue("R6 single");
        put(0, 0, 4'd0, 2'd0, 2'd0, 4'd0); put(1, 0, 4'd0, 2'd0, 2'd0, 4'd0);  issue("R6 idle");
        // R7: back-to-back fused pairs keep advancing the count by two
        put(0, 1, 4'd1, 2'd2, 2'd1, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd12); issue("R7 fused-a");
        put(0, 1, 4'd4, 2'd1, 2'd3, 4'd0); put(1, 1, 4'd7, 2'd0, 2'd0, 4'd15); issue("R7 fused-b");
        put(0, 0, 4'd0, 2'd0, 2'd0, 4'd0); put(1, 0, 4'd0, 2'd0, 2'd0, 4'd0);  issue("R7 drain");

        @(negedge clk);
        in_valid = '0;
        while (sb.size() > 0) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule